// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drains a ring of transmit descriptors that a host has prepared in memory. Each descriptor occupies eight bytes and names a buffer, a byte count and a status byte. When the host sets a descriptor's status so that the controller owns it and it holds one whole packet, the engine fetches the count and the buffer address and sends the buffer's bytes on a byte-stream output with a valid/ready handshake. It then rewrites the status byte to give the descriptor back to the host and pulses a completion strobe.

The host starts a scan with a one-cycle kick while the enable input is high. The scan starts at the engine's current ring position and sends descriptors one after another. It stops at the first descriptor that does not qualify, when the enable is low before a descriptor is fetched, or after one entry fewer than the ring holds. All memory traffic goes through one byte-wide request/acknowledge port, with no more than one access in flight.

Top module: `txdesc_ring_engine`

## Requirements
- R1: After reset, mem_req, out_valid, out_last and tx_done are low and the ring position is entry 0.
- R2: Descriptor i sits at RING_BASE + 8*i. Its byte at offset 2 is the status. Offsets 4 (high byte) and 5 (low byte) hold the stored length L. The buffer address is {byte 3, byte 0, byte 1} (bits 23:16, 15:8, 7:0), cut to ADDR_W bits.
- R3: A descriptor is taken only when its status byte is exactly 8'h83. Any other value ends the scan: no byte is sent, nothing is written and the ring position does not move.
- R4: The number of bytes sent is (65536 - L) mod 65536. They are sent from consecutive rising buffer addresses, and out_last is high on the final byte only.
- R5: A stored length of 0 sends no bytes, but the descriptor is still written back and completed.
- R6: After the last byte, the engine writes 8'h03 to the status byte. It then raises tx_done for exactly one cycle, once per frame. 8'h03 is the only value the engine ever writes.
- R7: The ring position advances by one, modulo 2**RING_LOG, for each frame sent. The next kick resumes there, wrapping from the last entry to entry 0.
- R8: One kick sends at most 2**RING_LOG - 1 descriptors.
- R9: A kick while tx_enable is low starts nothing. If tx_enable falls during a frame, that frame completes and no further descriptor is fetched.
- R10: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold.
- R11: mem_req stays high with a stable address and direction until mem_ack. No request is made while an output byte is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | Start a scan (one-cycle pulse) |
| tx_enable | input | 1 | Scans may run only while high |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access complete (one cycle) |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |
| out_ready | input | 1 | Sink accepts the byte |
| tx_done | output | 1 | One-cycle pulse per completed frame |

## Verification
The main path is tried in several ways:
- A single five-byte frame, which checks the address assembly, the length negation and the placement of the last flag.
- Status values that miss 8'h83 by one bit in either direction, which separate an exact match from a test of the owner bit alone.
- A zero-length descriptor, which separates "send nothing but complete" from skipping it.
- A ring filled in every entry and sent under backpressure, which shows the one-short scan limit, the wrap to entry 0 and output holding under stalls.
- Dropping the enable partway through a frame, which shows that the current frame finishes and the next descriptor is left untouched.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_STAT, S_LENH, S_LENL,
    S_AD0, S_AD1, S_AD3, S_BYTE, S_PUSH, S_WB
  } tdr_state_e;

  localparam logic [7:0] STAT_READY = 8'h83;
  localparam logic [7:0] STAT_DONE  = 8'h03;

  localparam int OFF_ALO  = 0;
  localparam int OFF_AMID = 1;
  localparam int OFF_STAT = 2;
  localparam int OFF_AHI  = 3;
  localparam int OFF_LENH = 4;
  localparam int OFF_LENL = 5;
endpackage

// File: rtl/tdr_ring_index.sv
module tdr_ring_index #(
  parameter int RING_LOG = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                advance,
  output logic [RING_LOG-1:0] idx,
  output logic                scan_full
);
  localparam int RING_SIZE = 1 << RING_LOG;
  localparam logic [RING_LOG-1:0] SCAN_MAX = RING_LOG'(RING_SIZE - 1);

  logic [RING_LOG-1:0] scan_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      scan_cnt <= '0;
    end else begin
      if (advance) idx <= idx + 1'b1;
      if (start)        scan_cnt <= '0;
      else if (advance) scan_cnt <= scan_cnt + 1'b1;
    end
  end

  assign scan_full = (scan_cnt == SCAN_MAX);
endmodule

// File: rtl/tdr_len_decode.sv
module tdr_len_decode (
  input  logic [7:0]  len_hi,
  input  logic [7:0]  len_lo,
  output logic [15:0] count,
  output logic        is_zero
);
  logic [15:0] raw;
  assign raw     = {len_hi, len_lo};
  assign count   = ~raw + 16'd1;
  assign is_zero = (raw == 16'd0);
endmodule

// File: rtl/tdr_addr_gen.sv
module tdr_addr_gen #(
  parameter int ADDR_W    = 10,
  parameter int RING_LOG  = 2,
  parameter int RING_BASE = 0
) (
  input  logic [RING_LOG-1:0] idx,
  output logic [ADDR_W-1:0]   desc_base
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(RING_BASE);
  assign desc_base = BASE + ADDR_W'({idx, 3'b000});
endmodule

// File: rtl/tdr_byte_out.sv
module tdr_byte_out (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic       load_last,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       fire
);
  assign fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
      out_last  <= load_last;
    end else if (fire) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/txdesc_ring_engine.sv
module txdesc_ring_engine #(
  parameter int ADDR_W    = 10,
  parameter int RING_LOG  = 2,
  parameter int RING_BASE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick,
  input  logic              tx_enable,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  input  logic              out_ready,
  output logic              tx_done
);
  import tdr_pkg::*;

  localparam int BUF_AW = 24;

  tdr_state_e          state;
  logic [RING_LOG-1:0] idx;
  logic                scan_full;
  logic [ADDR_W-1:0]   desc_base;
  logic [7:0]          len_hi, len_lo;
  logic [15:0]         count;
  logic                len_zero;
  logic [BUF_AW-1:0]   buf_addr;
  logic [15:0]         remain;
  logic                fire;
  logic                scan_start;
  logic                advance;
  logic                byte_load;

  assign scan_start = (state == S_IDLE) && kick && tx_enable;
  assign advance    = (state == S_WB) && mem_ack;
  assign byte_load  = (state == S_BYTE) && mem_ack;

  tdr_ring_index #(.RING_LOG(RING_LOG)) u_index (
    .clk(clk), .rst(rst), .start(scan_start), .advance(advance),
    .idx(idx), .scan_full(scan_full)
  );

  tdr_addr_gen #(.ADDR_W(ADDR_W), .RING_LOG(RING_LOG), .RING_BASE(RING_BASE)) u_addr (
    .idx(idx), .desc_base(desc_base)
  );

  tdr_len_decode u_len (
    .len_hi(len_hi), .len_lo(len_lo), .count(count), .is_zero(len_zero)
  );

  tdr_byte_out u_out (
    .clk(clk), .rst(rst), .load(byte_load), .load_data(mem_rdata),
    .load_last(remain == 16'd1), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .fire(fire)
  );

  function automatic logic [ADDR_W-1:0] at(input logic [ADDR_W-1:0] base, input int off);
    return base + ADDR_W'(off);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= 8'h00;
      len_hi    <= 8'h00;
      len_lo    <= 8'h00;
      buf_addr  <= '0;
      remain    <= 16'd0;
      tx_done   <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (kick && tx_enable) state <= S_CHK;
        end
        S_CHK: begin
          if (!tx_enable || scan_full) begin
            state <= S_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= at(desc_base, OFF_STAT);
            state    <= S_STAT;
          end
        end
        S_STAT: begin
          if (mem_ack) begin
            if (mem_rdata == STAT_READY) begin
              mem_addr <= at(desc_base, OFF_LENH);
              state    <= S_LENH;
            end else begin
              mem_req <= 1'b0;
              state   <= S_IDLE;
            end
          end
        end
        S_LENH: begin
          if (mem_ack) begin
            len_hi   <= mem_rdata;
            mem_addr <= at(desc_base, OFF_LENL);
            state    <= S_LENL;
          end
        end
        S_LENL: begin
          if (mem_ack) begin
            len_lo   <= mem_rdata;
            mem_addr <= at(desc_base, OFF_ALO);
            state    <= S_AD0;
          end
        end
        S_AD0: begin
          if (mem_ack) begin
            buf_addr[15:8] <= mem_rdata;
            mem_addr       <= at(desc_base, OFF_AMID);
            state          <= S_AD1;
          end
        end
        S_AD1: begin
          if (mem_ack) begin
            buf_addr[7:0] <= mem_rdata;
            mem_addr      <= at(desc_base, OFF_AHI);
            state         <= S_AD3;
          end
        end
        S_AD3: begin
          if (mem_ack) begin
            buf_addr[23:16] <= mem_rdata;
            if (len_zero) begin
              mem_we    <= 1'b1;
              mem_wdata <= STAT_DONE;
              mem_addr  <= at(desc_base, OFF_STAT);
              state     <= S_WB;
            end else begin
              remain   <= count;
              mem_addr <= {mem_rdata, buf_addr[15:0]}[ADDR_W-1:0];
              state    <= S_BYTE;
            end
          end
        end
        S_BYTE: begin
          if (mem_ack) begin
            mem_req  <= 1'b0;
            buf_addr <= buf_addr + 1'b1;
            state    <= S_PUSH;
          end
        end
        S_PUSH: begin
          if (fire) begin
            remain  <= remain - 16'd1;
            mem_req <= 1'b1;
            if (remain == 16'd1) begin
              mem_we    <= 1'b1;
              mem_wdata <= STAT_DONE;
              mem_addr  <= at(desc_base, OFF_STAT);
              state     <= S_WB;
            end else begin
              mem_addr <= buf_addr[ADDR_W-1:0];
              state    <= S_BYTE;
            end
          end
        end
        S_WB: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            tx_done <= 1'b1;
            state   <= S_CHK;
          end
        end
        default: begin
          mem_req <= 1'b0;
          state   <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/tdr_checker.sv
module tdr_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mem_ack,
  input logic              out_valid,
  input logic [7:0]        out_data,
  input logic              out_last,
  input logic              out_ready,
  input logic              tx_done
);
  // R1: outputs quiet in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!mem_req && !out_valid && !out_last && !tx_done));

  // R10: output byte held while stalled
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R11: request held with stable address until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R11: no memory request while a byte waits at the output
  a_r11_no_req_with_byte: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !mem_req);

  // R6: only the release value is ever written
  a_r6_write_value: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata == 8'h03));

  // R6: completion follows an acknowledged write and lasts one cycle
  a_r6_done_after_write: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> $past(mem_req && mem_we && mem_ack));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);

  // R4: last flag only accompanies a valid byte
  a_r4_last_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
endmodule

bind txdesc_ring_engine tdr_checker #(.ADDR_W(ADDR_W)) u_tdr_checker (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
  .out_ready(out_ready), .tx_done(tx_done)
);

// File: tb/txdesc_ring_engine_test.sv
`timescale 1ns/1ps
module txdesc_ring_engine_test;
  localparam int ADDR_W = 10;
  localparam int MEM_SZ = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kick = 1'b0;
  logic tx_enable = 1'b1;
  logic mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [7:0] mem_rdata = 8'h00;
  logic out_valid, out_last, tx_done;
  logic [7:0] out_data;
  logic out_ready = 1'b1;

  always #4 clk = ~clk;

  txdesc_ring_engine #(.ADDR_W(ADDR_W), .RING_LOG(2), .RING_BASE(0)) uut (
    .clk(clk), .rst(rst), .kick(kick), .tx_enable(tx_enable),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready), .tx_done(tx_done)
  );

  logic [7:0] mem [0:MEM_SZ-1];

  // memory responder: acknowledges one cycle after a fresh request
  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr] = mem_wdata;
      else mem_rdata <= mem[mem_addr];
    end else mem_ack <= 1'b0;
  end

  int checks = 0, errors = 0;
  int cap_n = 0, done_cnt = 0, stall_err = 0, cyc = 0;
  logic [7:0] cap_data [0:255];
  logic       cap_last [0:255];
  bit bp = 0;
  bit prev_stall = 0;
  logic [7:0] prev_data;
  bit finished = 0;

  // sink and monitor, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (prev_stall && (!out_valid || out_data !== prev_data)) stall_err++;
    out_ready = bp ? (cyc % 3 == 0) : 1'b1;
    if (out_valid && out_ready && cap_n < 256) begin
      cap_data[cap_n] = out_data;
      cap_last[cap_n] = out_last;
      cap_n++;
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    if (tx_done) done_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_desc(input int i, input logic [7:0] st, input logic [15:0] len,
                          input logic [15:0] addr);
    mem[8*i+0] = addr[15:8];
    mem[8*i+1] = addr[7:0];
    mem[8*i+2] = st;
    mem[8*i+3] = 8'h00;
    mem[8*i+4] = len[15:8];
    mem[8*i+5] = len[7:0];
  endtask

  task automatic clear_cap();
    cap_n = 0; done_cnt = 0; stall_err = 0;
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic wait_quiet();
    int quiet = 0;
    while (quiet < 10) begin
      @(negedge clk);
      if (mem_req || out_valid) quiet = 0; else quiet++;
    end
  endtask

  task automatic check_frame(input int first, input int addr, input int n, input string req);
    bit ok = 1;
    for (int k = 0; k < n; k++) begin
      if (cap_data[first+k] !== mem[addr+k]) ok = 0;
      if (cap_last[first+k] !== (k == n-1)) ok = 0;
    end
    check(ok, req, first, addr);
  endtask

  task automatic t_reset();
    check(!mem_req && !out_valid && !out_last && !tx_done, "R1", {mem_req, out_valid, tx_done}, 0);
  endtask

  task automatic t_single();
    clear_cap();
    set_desc(0, 8'h83, 16'hFFFB, 16'h0240);
    set_desc(1, 8'h00, 16'h0000, 16'h0000);
    pulse_kick(); wait_quiet();
    check(cap_n == 5, "R4 count", cap_n, 5);
    check_frame(0, 'h240, 5, "R2 R4 bytes from entry 0 (R1 start)");
    check(mem[2] == 8'h03, "R6 writeback", mem[2], 8'h03);
    check(done_cnt == 1, "R6 done pulses", done_cnt, 1);
  endtask

  task automatic t_reject();
    clear_cap();
    set_desc(1, 8'h82, 16'hFFFD, 16'h0250);
    set_desc(2, 8'h00, 16'h0000, 16'h0000);
    pulse_kick(); wait_quiet();
    check(cap_n == 0 && done_cnt == 0, "R3 0x82 rejected", cap_n, 0);
    check(mem[10] == 8'h82, "R3 status untouched", mem[10], 8'h82);
    mem[10] = 8'h87;
    pulse_kick(); wait_quiet();
    check(cap_n == 0 && mem[10] == 8'h87, "R3 0x87 rejected", mem[10], 8'h87);
    mem[10] = 8'h83;
    pulse_kick(); wait_quiet();
    check(cap_n == 3, "R3 position kept at entry 1", cap_n, 3);
    check_frame(0, 'h250, 3, "R3 frame of entry 1");
  endtask

  task automatic t_zero();
    clear_cap();
    set_desc(2, 8'h83, 16'h0000, 16'h0260);
    set_desc(3, 8'h00, 16'h0000, 16'h0000);
    pulse_kick(); wait_quiet();
    check(cap_n == 0, "R5 no bytes", cap_n, 0);
    check(mem[18] == 8'h03 && done_cnt == 1, "R5 completed", mem[18], 8'h03);
  endtask

  task automatic t_wrap_limit();
    clear_cap();
    set_desc(3, 8'h83, 16'hFFFC, 16'h0300);
    set_desc(0, 8'h83, 16'hFFFE, 16'h0310);
    set_desc(1, 8'h83, 16'hFFFD, 16'h0320);
    set_desc(2, 8'h83, 16'hFFFF, 16'h0330);
    bp = 1;
    pulse_kick(); wait_quiet();
    check(done_cnt == 3, "R8 three frames per kick", done_cnt, 3);
    check(mem[18] == 8'h83, "R8 fourth entry untouched", mem[18], 8'h83);
    check(cap_n == 9, "R7 bytes across wrap", cap_n, 9);
    check_frame(0, 'h300, 4, "R7 entry 3");
    check_frame(4, 'h310, 2, "R7 entry 0 after wrap");
    check_frame(6, 'h320, 3, "R7 entry 1");
    check(stall_err == 0, "R10 hold under backpressure", stall_err, 0);
    clear_cap();
    pulse_kick(); wait_quiet();
    check(cap_n == 1 && done_cnt == 1, "R7 resume at entry 2", cap_n, 1);
    check_frame(0, 'h330, 1, "R4 single byte last");
    bp = 0;
  endtask

  task automatic t_enable();
    clear_cap();
    set_desc(3, 8'h83, 16'hFFFE, 16'h0340);
    set_desc(0, 8'h83, 16'hFFFA, 16'h0350);
    tx_enable = 1'b0;
    pulse_kick(); wait_quiet();
    check(cap_n == 0 && mem[26] == 8'h83, "R9 kick ignored while disabled", cap_n, 0);
    tx_enable = 1'b1;
    pulse_kick();
    while (cap_n < 1) @(negedge clk);
    tx_enable = 1'b0;
    wait_quiet();
    check(cap_n == 2 && done_cnt == 1, "R9 current frame finishes", cap_n, 2);
    check(mem[26] == 8'h03 && mem[2] == 8'h83, "R9 next entry untouched", mem[2], 8'h83);
    tx_enable = 1'b1;
  endtask

  initial begin
    for (int k = 0; k < MEM_SZ; k++) mem[k] = 8'((k * 13) + 5);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_reject();
    t_zero();
    t_wrap_limit();
    t_enable();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule